// File: doc/BRIEF.md
# SHA-1 Block Compression Core

This block applies the SHA-1 compression function to one 512-bit message block at a time. It runs one round per clock for 80 rounds, then spends one more cycle folding the working words into the five 32-bit chaining words. Padding and length encoding are done upstream. The caller presents blocks that are already padded.

A message starts with a `start_msg` pulse, which seeds the chaining words with the standard SHA-1 initial values. Each later block of the same message is sent with `cont_msg`, which carries on from whatever `hash_out` currently holds. The intermediate digest can be read after every block, and `hash_ok` marks it as valid. A command is taken only while `idle` is high. The block word is captured on the accepting edge, so `blk_data` may change freely once the run has started.

Top module: `sha1c_top`

## Requirements
- R1: While and after reset, before any command, `idle` is 1, `hash_ok` is 0 and `hash_out` is all zeros.
- R2: A `start_msg` accepted while idle hashes `blk_data` from the initial chaining value 67452301 efcdab89 98badcfe 10325476 c3d2e1f0. Message word 0 is taken from `blk_data[511:480]`, and chaining word 0 appears at `hash_out[159:128]`. The padded message "abc" gives a9993e364706816aba3e25717850c26c9cd0d89d.
- R3: A `cont_msg` accepted while idle hashes `blk_data` from the current `hash_out`. This includes the all-zero value left by reset. The standard 448-bit two-block message gives f4286818c37b27ae0408f581846771484a566572 after its first block and 84983e441c3bd26ebaae4aa1f95129e5e54670f1 after its second.
- R4: `idle` falls in the cycle after a command is accepted. It stays low for exactly 81 cycles (80 rounds and one fold cycle) and then returns high.
- R5: `hash_ok` is 0 in the cycle after a command is accepted and stays 0 while busy. It rises in the same cycle as `idle` returns high.
- R6: While busy, `start_msg`, `cont_msg` and `blk_data` have no effect. The run length and the resulting digest are those of the accepted block.
- R7: From the cycle after acceptance until completion, `hash_out` holds a single value. That value is the initial chaining value after `start_msg`, or the previous digest after `cont_msg`.
- R8: When `start_msg` and `cont_msg` are both high at acceptance, `start_msg` takes priority.
- R9: While idle with no command, `hash_out` and `hash_ok` keep their values.
- R10: A `start_msg` after a chain of blocks discards the chain and restarts from the initial chaining value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_msg | input | 1 | Begin a new message with this block |
| cont_msg | input | 1 | Chain this block onto the current digest |
| blk_data | input | 512 | Padded message block, word 0 in the top bits |
| idle | output | 1 | High when a command can be accepted |
| hash_out | output | 160 | Chaining words H0..H4, H0 in the top bits |
| hash_ok | output | 1 | `hash_out` holds the digest of the last block |

## Verification
The embedded properties assume that reset is applied before the first command and that both command inputs are at known levels at every rising edge. They place no limit on how long a command is held or on when it is raised. The stimulus changes inputs only on falling edges. Normal commands are one-cycle pulses issued while `idle` is high. The bench also raises both commands and alters `blk_data` in the middle of a run, on purpose, to check that a busy core ignores them. Expected digests come from a separate reference compression written in the bench, and this reference is checked against the published test vectors.

// File: rtl/sha1c_pkg.sv
`timescale 1ns/1ps
package sha1c_pkg;
  localparam int WORD_W = 32;
  localparam int N_H    = 5;
  localparam int BLK_W  = 512;
  localparam int DIG_W  = WORD_W * N_H;

  typedef logic [WORD_W-1:0] word_t;
  // element 0 (H0 / a) sits in the most significant bits
  typedef word_t [0:N_H-1] hset_t;
  typedef logic [1:0] grp_t;
  typedef enum logic [1:0] {PH_IDLE, PH_ROUND, PH_FOLD} phase_t;

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic grp_t grp_of(input int r, input int len);
    return grp_t'(r / len);
  endfunction

  // Round function by group: choose, parity, majority, parity
  function automatic word_t mix_f(input grp_t g, input word_t b, input word_t c, input word_t d);
    case (g)
      2'd0:    return d ^ (b & (c ^ d));
      2'd2:    return (b & c) | (d & (b | c));
      default: return b ^ c ^ d;
    endcase
  endfunction

  function automatic word_t grp_k(input grp_t g);
    case (g)
      2'd0:    return 32'h5a827999;
      2'd1:    return 32'h6ed9eba1;
      2'd2:    return 32'h8f1bbcdc;
      default: return 32'hca62c1d6;
    endcase
  endfunction

  function automatic word_t iv_word(input int i);
    case (i)
      0:       return 32'h67452301;
      1:       return 32'hefcdab89;
      2:       return 32'h98badcfe;
      3:       return 32'h10325476;
      default: return 32'hc3d2e1f0;
    endcase
  endfunction

  function automatic hset_t iv_set();
    hset_t s;
    for (int i = 0; i < N_H; i++) s[i] = iv_word(i);
    return s;
  endfunction
endpackage

// File: rtl/sha1c_ctrl.sv
`timescale 1ns/1ps
module sha1c_ctrl
  import sha1c_pkg::*;
#(
  parameter int ROUNDS = 80,
  localparam int CNT_W = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cont_i,
  output logic             accept_o,
  output logic             load_iv_o,
  output logic             step_o,
  output logic             fold_o,
  output logic             idle_o,
  output logic [CNT_W-1:0] rnd_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

  phase_t           ph_q;
  logic [CNT_W-1:0] cnt_q;

  assign idle_o    = (ph_q == PH_IDLE);
  assign accept_o  = idle_o & (start_i | cont_i);
  assign load_iv_o = accept_o & start_i;
  assign step_o    = (ph_q == PH_ROUND);
  assign fold_o    = (ph_q == PH_FOLD);
  assign rnd_o     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (accept_o) begin
          ph_q  <= PH_ROUND;
          cnt_q <= '0;
        end
        PH_ROUND: if (cnt_q == LAST) ph_q <= PH_FOLD;
                  else cnt_q <= cnt_q + 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (step_o && rnd_o == '0));
  assert_last_round_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && rnd_o == LAST) |=> fold_o);
  assert_fold_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fold_o |=> idle_o);
  // commands during a run must not restart or stall the count
  assert_round_walk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && rnd_o != LAST) |=> (step_o && rnd_o == $past(rnd_o) + 1'b1));
endmodule

// File: rtl/sha1c_sched.sv
`timescale 1ns/1ps
module sha1c_sched
  import sha1c_pkg::*;
#(
  parameter int WORDS = BLK_W / WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [BLK_W-1:0] blk_i,
  output word_t            w_o
);
  // recurrence taps relative to the oldest word of the window
  localparam int TAP_3  = WORDS - 3;
  localparam int TAP_8  = WORDS - 8;
  localparam int TAP_14 = WORDS - 14;

  word_t win_q [WORDS];
  word_t fresh;

  assign fresh = rotl(win_q[TAP_3] ^ win_q[TAP_8] ^ win_q[TAP_14] ^ win_q[0], 1);
  assign w_o   = win_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) win_q[i] <= '0;
    end else if (load_i) begin
      for (int i = 0; i < WORDS; i++) win_q[i] <= blk_i[BLK_W-1-WORD_W*i -: WORD_W];
    end else if (step_i) begin
      for (int i = 0; i < WORDS-1; i++) win_q[i] <= win_q[i+1];
      win_q[WORDS-1] <= fresh;
    end
  end

  assert_window_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(w_o));
endmodule

// File: rtl/sha1c_work.sv
`timescale 1ns/1ps
module sha1c_work
  import sha1c_pkg::*;
#(
  parameter int ROUNDS    = 80,
  parameter int GROUP_LEN = ROUNDS / 4,
  localparam int CNT_W    = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             load_iv_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] rnd_i,
  input  word_t            w_i,
  input  hset_t            h_i,
  output hset_t            v_o
);
  hset_t v_q;
  grp_t  grp;
  word_t tsum;

  always_comb begin
    grp  = grp_of(int'(rnd_i), GROUP_LEN);
    tsum = rotl(v_q[0], 5) + mix_f(grp, v_q[1], v_q[2], v_q[3]) + v_q[4] + grp_k(grp) + w_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else if (load_i) begin
      for (int i = 0; i < N_H; i++) v_q[i] <= load_iv_i ? iv_word(i) : h_i[i];
    end else if (step_i) begin
      v_q[0] <= tsum;
      v_q[1] <= v_q[0];
      v_q[2] <= rotl(v_q[1], 30);
      v_q[3] <= v_q[2];
      v_q[4] <= v_q[3];
    end
  end

  assign v_o = v_q;

  assert_work_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(v_o));
  assert_work_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_iv_i) |=> (v_o == iv_set()));
endmodule

// File: rtl/sha1c_chain.sv
`timescale 1ns/1ps
module sha1c_chain
  import sha1c_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_iv_i,
  input  logic  fold_i,
  input  hset_t v_i,
  output hset_t h_o
);
  hset_t h_q;

  for (genvar g = 0; g < N_H; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         h_q[g] <= '0;
      else if (load_iv_i) h_q[g] <= iv_word(g);
      else if (fold_i)    h_q[g] <= h_q[g] + v_i[g];
    end
  end

  assign h_o = h_q;

  assert_seed_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_iv_i |=> (h_o == iv_set()));
  assert_chain_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_iv_i && !fold_i) |=> $stable(h_o));
endmodule

// File: rtl/sha1c_top.sv
`timescale 1ns/1ps
module sha1c_top
  import sha1c_pkg::*;
#(
  parameter int ROUNDS    = 80,
  parameter int GROUP_LEN = ROUNDS / 4,
  localparam int CNT_W    = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_msg,
  input  logic             cont_msg,
  input  logic [511:0]     blk_data,
  output logic             idle,
  output logic [159:0]     hash_out,
  output logic             hash_ok
);
  logic             accept, load_iv, step, fold;
  logic [CNT_W-1:0] rnd;
  word_t            w_cur;
  hset_t            work_v, chain_h;
  logic             ok_q;

  sha1c_ctrl #(.ROUNDS(ROUNDS)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_msg), .cont_i(cont_msg),
    .accept_o(accept), .load_iv_o(load_iv), .step_o(step), .fold_o(fold),
    .idle_o(idle), .rnd_o(rnd)
  );

  sha1c_sched i_sched (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .step_i(step),
    .blk_i(blk_data), .w_o(w_cur)
  );

  sha1c_work #(.ROUNDS(ROUNDS), .GROUP_LEN(GROUP_LEN)) i_work (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .load_iv_i(load_iv),
    .step_i(step), .rnd_i(rnd), .w_i(w_cur), .h_i(chain_h), .v_o(work_v)
  );

  sha1c_chain i_chain (
    .clk(clk), .rst_n(rst_n), .load_iv_i(load_iv), .fold_i(fold),
    .v_i(work_v), .h_o(chain_h)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ok_q <= 1'b0;
    else if (accept) ok_q <= 1'b0;
    else if (fold)   ok_q <= 1'b1;
  end

  assign hash_out = chain_h;
  assign hash_ok  = ok_q;

  assert_valid_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !hash_ok);
  assert_valid_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fold |=> (hash_ok && idle));
  assert_busy_not_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> !hash_ok);
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !start_msg && !cont_msg) |=> ($stable(hash_out) && $stable(hash_ok)));
endmodule

// File: tb/test_sha1c_top.sv
`timescale 1ns/1ps
module test_sha1c_top;
  localparam logic [159:0] IV_REF = 160'h67452301_efcdab89_98badcfe_10325476_c3d2e1f0;
  localparam int BUSY_LEN = 81;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_msg = 1'b0;
  logic         cont_msg = 1'b0;
  logic [511:0] blk_data = '0;
  logic         idle;
  logic [159:0] hash_out;
  logic         hash_ok;

  int n_checks = 0;
  int n_bad = 0;
  logic [159:0] model_h = '0;
  logic [159:0] exp_q[$];
  string        tag_q[$];
  logic         ok_prev = 1'b0;
  bit           finished = 1'b0;

  sha1c_top i_sha1c_top (
    .clk(clk), .rst_n(rst_n), .start_msg(start_msg), .cont_msg(cont_msg),
    .blk_data(blk_data), .idle(idle), .hash_out(hash_out), .hash_ok(hash_ok)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] expv);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} << n;
    return d[63:32];
  endfunction

  // reference compression, written with a full 80-entry schedule
  function automatic logic [159:0] ref_compress(input logic [159:0] h, input logic [511:0] m);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, tmp;
    for (int i = 0; i < 16; i++) w[i] = m[511-32*i -: 32];
    for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    {a, b, c, d, e} = h;
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5a827999; end
      else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ed9eba1; end
      else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8f1bbcdc; end
      else             begin f = b ^ c ^ d;                   k = 32'hca62c1d6; end
      tmp = rl(a, 5) + f + e + k + w[i];
      e = d; d = c; c = rl(b, 30); b = a; a = tmp;
    end
    return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
  endfunction

  function automatic logic [511:0] mk_block(input int seed);
    logic [511:0] r;
    logic [31:0]  x;
    for (int i = 0; i < 16; i++) begin
      x = 32'h9e3779b9 * 32'(seed * 16 + i + 1);
      x = x ^ (x >> 13) ^ 32'(seed);
      r[511-32*i -: 32] = x;
    end
    return r;
  endfunction

  // scoreboard monitor: compare on every rising edge of hash_ok
  always @(negedge clk) begin
    if (!rst_n) ok_prev = 1'b0;
    else begin
      if (hash_ok && !ok_prev) begin
        if (exp_q.size() == 0) check(1'b0, "R5 unexpected completion", hash_out, '0);
        else begin
          logic [159:0] e1;
          string        t1;
          e1 = exp_q.pop_front();
          t1 = tag_q.pop_front();
          check(hash_out == e1, {t1, " digest"}, hash_out, e1);
        end
      end
      ok_prev = hash_ok;
    end
  end

  // driver: one block from a falling edge while idle; returns when idle again
  task automatic run_block(input bit s, input bit c, input logic [511:0] blk,
                           input int inj_at, input string req);
    logic [159:0] expd, held;
    int cnt;
    bit moved, done;
    while (!idle) @(negedge clk);
    expd = s ? ref_compress(IV_REF, blk) : ref_compress(model_h, blk);
    exp_q.push_back(expd);
    tag_q.push_back(req);
    start_msg = s; cont_msg = c; blk_data = blk;
    @(negedge clk);
    start_msg = 1'b0; cont_msg = 1'b0;
    check(!idle, "R4 idle low after accept", 160'(idle), 160'(0));
    check(!hash_ok, "R5 valid cleared after accept", 160'(hash_ok), 160'(0));
    held = hash_out;
    check(held == (s ? IV_REF : model_h), "R7 chaining value during run", held, s ? IV_REF : model_h);
    cnt = 1; moved = 1'b0; done = 1'b0;
    while (!done) begin
      @(negedge clk);
      if (idle) done = 1'b1;
      else begin
        cnt++;
        if (hash_out != held) moved = 1'b1;
        if (cnt == inj_at) begin
          start_msg = 1'b1; cont_msg = 1'b1; blk_data = ~blk;
        end else if (cnt == inj_at + 1) begin
          start_msg = 1'b0; cont_msg = 1'b0;
        end
        if (cnt > 400) done = 1'b1;
      end
    end
    check(!moved, "R7 hash_out stable while busy", 160'(moved), 160'(0));
    check(cnt == BUSY_LEN, "R4 busy length", 160'(cnt), 160'(BUSY_LEN));
    check(hash_ok, "R5 valid with idle", 160'(hash_ok), 160'(1));
    model_h = expd;
  endtask

  initial begin
    logic [511:0] abc, two_a, two_b, pat;
    logic [159:0] snap;
    abc   = {32'h61626380, 448'h0, 32'h00000018};
    two_a = {448'h61626364_62636465_63646566_64656667_65666768_66676869_6768696a_68696a6b_696a6b6c_6a6b6c6d_6b6c6d6e_6c6d6e6f_6d6e6f70_6e6f7071,
             64'h80000000_00000000};
    two_b = {480'h0, 32'h000001c0};

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(idle, "R1 idle in reset", 160'(idle), 160'(1));
    check(!hash_ok, "R1 valid in reset", 160'(hash_ok), 160'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(idle && !hash_ok && hash_out == '0, "R1 state after reset",
          {hash_out[157:0], idle, hash_ok}, 160'h2);

    // reference model self-check against published vectors
    check(ref_compress(IV_REF, abc) == 160'ha9993e364706816aba3e25717850c26c9cd0d89d,
          "R2 bench reference", ref_compress(IV_REF, abc), 160'ha9993e364706816aba3e25717850c26c9cd0d89d);

    // R3: chaining from the zero value left by reset
    run_block(1'b0, 1'b1, mk_block(7), 0, "R3 chain from zero");

    // R2: "abc"
    run_block(1'b1, 1'b0, abc, 0, "R2 abc");
    check(hash_out == 160'ha9993e364706816aba3e25717850c26c9cd0d89d, "R2 abc vector",
          hash_out, 160'ha9993e364706816aba3e25717850c26c9cd0d89d);

    // R3: two-block message
    run_block(1'b1, 1'b0, two_a, 0, "R3 first block");
    check(hash_out == 160'hf4286818c37b27ae0408f581846771484a566572, "R3 first block vector",
          hash_out, 160'hf4286818c37b27ae0408f581846771484a566572);
    run_block(1'b0, 1'b1, two_b, 0, "R3 second block");
    check(hash_out == 160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1, "R3 second block vector",
          hash_out, 160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1);

    // R9: hold while idle
    snap = hash_out;
    repeat (16) @(negedge clk);
    check(hash_out == snap, "R9 digest held while idle", hash_out, snap);
    check(hash_ok, "R9 valid held while idle", 160'(hash_ok), 160'(1));

    // R6: commands and block changes during a run are ignored
    pat = mk_block(21);
    run_block(1'b1, 1'b0, pat, 40, "R6 poke mid-run");
    run_block(1'b0, 1'b1, mk_block(22), 2, "R6 poke early");

    // R8: both commands together, start wins
    run_block(1'b1, 1'b1, mk_block(33), 0, "R8 start priority");

    // R3: longer chain with varied blocks
    for (int s = 40; s < 44; s++) run_block(1'b0, 1'b1, mk_block(s), 0, "R3 multi-block chain");
    run_block(1'b0, 1'b1, '1, 0, "R3 all-ones block");

    // R10: restart after a chain
    run_block(1'b1, 1'b0, abc, 0, "R10 restart");
    check(hash_out == 160'ha9993e364706816aba3e25717850c26c9cd0d89d, "R10 restart vector",
          hash_out, 160'ha9993e364706816aba3e25717850c26c9cd0d89d);

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R5 all completions seen", 160'(exp_q.size()), 160'(0));
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end
endmodule